// File: doc/BRIEF.md
# Bus Cycle Timeout Monitor

This block watches every processor bus cycle and ends any cycle that no device answers. A cycle starts when the processor pulls either the chip-select strobe or the row-address strobe low. The monitor then counts system clocks until the addressed device returns the active-low transfer acknowledge. If the count reaches the selected limit with no acknowledge, the monitor sends a transfer-error pulse. That pulse ends the hung cycle, so the core can take an access-fault trap instead of waiting for ever.

The limit is chosen by a two-bit select field. The code 00 gives the longest window. Each higher code halves it. The monitor latches the field when a cycle starts and rearms on every new cycle. It never counts clocks while the bus is idle. Each timeout also sets a sticky status flag, which stays set until software pulses the clear input.

Top module: `bus_cycle_monitor`

## Requirements
- R1: While reset is held and on the first cycle after it, both `terr` and `tout_flag` are 0.
- R2: A cycle starts at a clock edge where the monitor is idle, `cs_n` or `ras_n` (or both) is low, and `ta_n` is high. This clock edge is the start edge.
- R3: The select code sets the limit L. 00 gives 1024 clocks, 01 gives 512, 10 gives 256 and 11 gives 128. If `ta_n` stays high, `terr` is high for the cycle that follows the L-th clock edge after the start edge, and at no earlier time.
- R4: If `ta_n` is sampled low at the k-th edge after the start edge, with 1 <= k < L, the cycle ends and no `terr` is produced. The next cycle counts its full window again from its own start edge.
- R5: If the acknowledge is sampled low at the same edge that would reach the limit (k = L), the acknowledge wins and `terr` stays 0.
- R6: `terr` is high for exactly one clock per timeout.
- R7: A timeout sets `tout_flag` to 1. The flag stays 1 until `sts_clr` is sampled high at a later edge. If a timeout and `sts_clr` fall on the same edge, the flag ends up set.
- R8: While both strobes are high, the monitor counts nothing and never produces `terr`, however long the idle time lasts.
- R9: The select code is latched at the start edge. Changing `tsel` during a cycle has no effect on that cycle's limit.
- R10: If `ta_n` is already low at the edge where a strobe first appears, the cycle is complete at once. No counting starts and no `terr` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip-select strobe, active low |
| ras_n | input | 1 | Row-address strobe, active low |
| ta_n | input | 1 | Transfer acknowledge, active low |
| tsel | input | 2 | Timeout select code |
| sts_clr | input | 1 | Clears the sticky timeout flag |
| terr | output | 1 | One-clock transfer-error pulse |
| tout_flag | output | 1 | Sticky timeout status |

## Verification
The assertions assume that the bus master releases both strobes in the clock after a cycle ends, whether it ends by acknowledge or by error. They also assume that `ta_n` reaches the monitor only while a cycle is open. The stimulus follows this rule. After every acknowledge or error, it drives the strobes high for at least one clock before the next cycle. Acknowledge delays and select codes are drawn at random between the directed cases, and one directed case moves `tsel` in the middle of a cycle.

// File: rtl/bmon_pkg.sv
package bmon_pkg;

    typedef enum logic {
        MON_IDLE   = 1'b0,
        MON_ACTIVE = 1'b1
    } mon_state_e;

    typedef logic [1:0] tsel_t;

    // Limit for a select code: the base window halved once per code step.
    function automatic int unsigned limit_of(input tsel_t code, input int unsigned base);
        return base >> code;
    endfunction

endpackage

// File: rtl/bmon_limit.sv
module bmon_limit
    import bmon_pkg::*;
#(
    parameter int unsigned BASE_LIMIT = 1024,
    localparam int CW = $clog2(BASE_LIMIT) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  tsel_t         code,
    output logic [CW-1:0] lim
);
    logic [CW-1:0] lim_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lim_q <= CW'(BASE_LIMIT);
        end else if (load) begin
            lim_q <= CW'(limit_of(code, BASE_LIMIT));
        end
    end

    assign lim = lim_q;

    // R9
    limit_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(lim_q));

endmodule

// File: rtl/bmon_counter.sv
module bmon_counter
    import bmon_pkg::*;
#(
    parameter int unsigned BASE_LIMIT = 1024,
    localparam int CW = $clog2(BASE_LIMIT) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          strobe,
    input  logic          ta_n,
    input  logic [CW-1:0] lim,
    output logic          start,
    output logic          active,
    output logic          hit
);
    mon_state_e    st;
    logic [CW-1:0] cnt;

    assign active = (st == MON_ACTIVE);
    assign start  = (st == MON_IDLE) && strobe && ta_n;
    assign hit    = active && ta_n && (cnt == lim);

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= MON_IDLE;
            cnt <= '0;
        end else begin
            unique case (st)
                MON_IDLE: begin
                    if (start) begin
                        st  <= MON_ACTIVE;
                        cnt <= CW'(1);
                    end
                end
                MON_ACTIVE: begin
                    if (!ta_n || hit) begin
                        st  <= MON_IDLE;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                default: begin
                    st  <= MON_IDLE;
                    cnt <= '0;
                end
            endcase
        end
    end

    // R8
    idle_no_count_chk: assert property (@(posedge clk) disable iff (rst)
        (st == MON_IDLE) |-> (cnt == '0));

    // R3
    cnt_within_lim_chk: assert property (@(posedge clk) disable iff (rst)
        active |-> (cnt <= lim) && (cnt != '0));

    // R4
    ack_ends_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (active && !ta_n) |=> !active);

endmodule

// File: rtl/bmon_flag.sv
module bmon_flag (
    input  logic clk,
    input  logic rst,
    input  logic hit,
    input  logic clr,
    output logic terr,
    output logic flag
);
    logic terr_q;
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            terr_q <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            terr_q <= hit;
            flag_q <= hit | (flag_q & ~clr);
        end
    end

    assign terr = terr_q;
    assign flag = flag_q;

    // R6
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        terr_q |=> !terr_q);

    // R7
    flag_sets_chk: assert property (@(posedge clk) disable iff (rst)
        hit |=> flag_q);

    // R7
    flag_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr) |=> flag_q);

endmodule

// File: rtl/bus_cycle_monitor.sv
module bus_cycle_monitor
    import bmon_pkg::*;
#(
    parameter int unsigned BASE_LIMIT = 1024
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       ras_n,
    input  logic       ta_n,
    input  logic [1:0] tsel,
    input  logic       sts_clr,
    output logic       terr,
    output logic       tout_flag
);
    localparam int CW = $clog2(BASE_LIMIT) + 1;

    logic          strobe;
    logic          start;
    logic          active;
    logic          hit;
    logic [CW-1:0] lim;

    assign strobe = ~cs_n | ~ras_n;

    bmon_limit #(.BASE_LIMIT(BASE_LIMIT)) limit_i (
        .clk  (clk),
        .rst  (rst),
        .load (start),
        .code (tsel),
        .lim  (lim)
    );

    bmon_counter #(.BASE_LIMIT(BASE_LIMIT)) count_i (
        .clk    (clk),
        .rst    (rst),
        .strobe (strobe),
        .ta_n   (ta_n),
        .lim    (lim),
        .start  (start),
        .active (active),
        .hit    (hit)
    );

    bmon_flag flag_i (
        .clk  (clk),
        .rst  (rst),
        .hit  (hit),
        .clr  (sts_clr),
        .terr (terr),
        .flag (tout_flag)
    );

    // R5
    ack_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (active && !ta_n) |=> !terr);

    // R10
    instant_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (!active && !ta_n) |=> !active);

    // R2
    start_on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (!active && strobe && ta_n) |=> active);

endmodule

// File: tb/bus_cycle_monitor_tb.sv
module bus_cycle_monitor_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst;
    logic       cs_n, ras_n, ta_n, sts_clr;
    logic [1:0] tsel;
    logic       terr, tout_flag;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_cycle_monitor dut_i (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .ta_n(ta_n),
        .tsel(tsel), .sts_clr(sts_clr), .terr(terr), .tout_flag(tout_flag)
    );

    function automatic int exp_limit(input logic [1:0] code);
        return 1024 >> code;
    endfunction

    function automatic int exp_first_err(input int lim, input int ack_at);
        if (ack_at >= 0 && ack_at <= lim) return -1;
        return lim;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // ack_at: edge index after start edge at which ta_n is low (0 = start edge, -1 = never)
    task automatic run_cycle(input bit use_ras, input logic [1:0] code, input int ack_at,
                             input bit move_sel, input bit clr_on_hit, input string req);
        int lim = exp_limit(code);
        int first = -1;
        int expf = exp_first_err(lim, ack_at);
        @(negedge clk);
        tsel = code;
        if (use_ras) ras_n = 1'b0; else cs_n = 1'b0;
        for (int i = 0; i <= lim; i++) begin
            ta_n = (i == ack_at) ? 1'b0 : 1'b1;
            if (move_sel && i == 1) tsel = ~code;
            if (clr_on_hit && i == lim) sts_clr = 1'b1;
            @(posedge clk);
            @(negedge clk);
            sts_clr = 1'b0;
            if (terr) begin first = i; break; end
            if (i == ack_at) break;
        end
        cs_n = 1'b1; ras_n = 1'b1; ta_n = 1'b1;
        check(first == expf, req, first, expf);
        if (first >= 0) begin
            check(tout_flag == 1'b1, "R7 flag set", int'(tout_flag), 1);
            @(posedge clk); @(negedge clk);
            check(terr == 1'b0, "R6 pulse width", int'(terr), 0);
        end else begin
            @(posedge clk); @(negedge clk);
            check(terr == 1'b0, req, int'(terr), 0);
        end
    endtask

    task automatic clear_flag();
        @(negedge clk); sts_clr = 1'b1;
        @(posedge clk); @(negedge clk); sts_clr = 1'b0;
        check(tout_flag == 1'b0, "R7 clear", int'(tout_flag), 0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        rst = 1'b1; cs_n = 1'b1; ras_n = 1'b1; ta_n = 1'b1; sts_clr = 1'b0; tsel = 2'b00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(terr == 1'b0 && tout_flag == 1'b0, "R1 during reset", int'({terr, tout_flag}), 0);
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        check(terr == 1'b0 && tout_flag == 1'b0, "R1 after reset", int'({terr, tout_flag}), 0);

        // R3: every code times out at its own limit; R2 via both strobes
        run_cycle(1'b0, 2'b00, -1, 1'b0, 1'b0, "R3 code00");
        run_cycle(1'b1, 2'b01, -1, 1'b0, 1'b0, "R3 code01 R2 ras");
        run_cycle(1'b0, 2'b10, -1, 1'b0, 1'b0, "R3 code10");
        run_cycle(1'b1, 2'b11, -1, 1'b0, 1'b0, "R3 code11");
        clear_flag();

        // R4: ack inside window, then a fresh full window
        run_cycle(1'b0, 2'b11, 127, 1'b0, 1'b0, "R4 late ack");
        run_cycle(1'b0, 2'b11, -1, 1'b0, 1'b0, "R4 reload");
        clear_flag();

        // R5: ack exactly at the limit edge
        run_cycle(1'b1, 2'b11, 128, 1'b0, 1'b0, "R5 ack at limit");
        check(tout_flag == 1'b0, "R5 no flag", int'(tout_flag), 0);

        // R10: ack on the start edge
        run_cycle(1'b0, 2'b11, 0, 1'b0, 1'b0, "R10 instant ack");
        repeat (140) @(posedge clk);
        @(negedge clk);
        check(terr == 1'b0 && tout_flag == 1'b0, "R10 no late error", int'({terr, tout_flag}), 0);

        // R9: select moved mid-cycle (11 latched, 00 driven afterwards)
        run_cycle(1'b0, 2'b11, -1, 1'b1, 1'b0, "R9 latched select");
        // R7: clear on same edge as timeout, set wins
        run_cycle(1'b1, 2'b10, -1, 1'b0, 1'b1, "R7 set beats clear");
        clear_flag();

        // R8: long idle with strobes high and acknowledge toggling
        begin
            int seen = 0;
            for (int i = 0; i < 1100; i++) begin
                @(negedge clk);
                ta_n = 1'($urandom);
                if (terr) seen++;
            end
            ta_n = 1'b1;
            check(seen == 0 && tout_flag == 1'b0, "R8 idle", seen, 0);
        end

        // random cycles
        for (int n = 0; n < 24; n++) begin
            logic [1:0] c = 2'($urandom);
            int lim = exp_limit(c);
            int a;
            case ($urandom % 4)
                0: a = -1;
                1: a = lim;
                default: a = int'($urandom % (lim + 4));
            endcase
            if (a > lim) a = -1;
            run_cycle(1'($urandom), c, a, 1'b0, 1'b0, "R4 random");
            if ($urandom % 3 == 0) clear_flag();
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule